// File: doc/BRIEF.md
# Pipelined Burst SRAM with No-Turnaround Protocol

This block is a synthesizable behavioural model of a single-port synchronous SRAM. Its data word is split into byte lanes (two 9-bit lanes by default) and its array is small. On every rising clock edge the control inputs are decoded into one command. The command can start a read or write burst at an external address, continue the running burst at its next address, deselect the part, or skip the edge entirely. Reads and writes use the same two-edge pipeline. Write data is taken two active edges after its address, and read data comes out two active edges after its address. Because of this, the bus can switch between reads and writes on consecutive cycles without idle cycles.

The data pins are modelled as an input word, an output word and a drive-enable output that controls an external pad driver. Output enable acts combinationally on that drive-enable. An asynchronous sleep input is synchronised over two edges. While asleep, the block keeps its array, drops any access in flight and does not drive the pins. After wake-up it treats all commands as deselects for a programmable number of cycles. The burst order within an aligned group of four words is chosen by a parameter: interleaved (XOR of the count) or linear (wrapping add).

Top module: `pbs_sram`

## Requirements
- R1: While reset is low, and in the first cycle after it, `drive_en` is 0 whatever the level of `oe`.
- R2: An active edge with `clk_hold`=0, `load`=1 and `sel`=1 starts a burst at `addr`. `wr`=0 starts a read and `wr`=1 starts a write. Read data of an address cycle is on `rdata` after the second active edge that follows it.
- R3: An active edge with `load`=0 continues the current burst, and `sel` and `wr` are ignored. The k-th continuation keeps the upper address bits of the start address. Its low two bits are the start bits XOR k (interleaved, default) or the start bits plus k modulo 4 (linear).
- R4: Write data is taken from `wdata` at the second active edge after its address cycle. `lane_we[0]` gates bits 8:0 and `lane_we[1]` gates bits 17:9. These lane enables are sampled in the address cycle. A write cycle with no lane enabled writes nothing but still uses its burst slot.
- R5: `drive_en` can be 1 only while the output stage holds a read. Write and deselect cycles never drive, even with `oe`=1.
- R6: `oe` gates `drive_en` combinationally, with no clock edge in between.
- R7: A read with `oe`=0 (dummy read) does not drive, but it still advances the burst address.
- R8: With `clk_hold`=1 the edge is ignored. The burst position, the pipeline and `rdata` hold their values.
- R9: A continuation when no burst is active (after a deselect) behaves as a deselect.
- R10: `sleep_req` takes effect after two edges and is released after two edges. While asleep, commands are ignored, pending accesses are dropped, `drive_en` is 0 and the array contents are kept.
- R11: For `REC_CYCLES` edges after sleep is left, every command is treated as a deselect.
- R12: A read issued in the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_hold | input | 1 | 1 = ignore this clock edge (wait state) |
| sel | input | 1 | Chip select for a load cycle, active high |
| load | input | 1 | 1 = new command at `addr`, 0 = continue burst |
| wr | input | 1 | 1 = write, 0 = read (load cycles) |
| lane_we | input | LANES | Per-lane write enables, sampled with the address |
| addr | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data, taken two active edges after its address |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep_req | input | 1 | Asynchronous sleep request |
| rdata | output | LANES*LANE_W | Read data toward the pad |
| drive_en | output | 1 | Pad driver enable for `rdata` |

## Verification
On every cycle, the assertions check four things. Output enable gates the pad drive. A write in the last pipeline stage never leads to a drive. A held edge freezes `rdata`. Sleep, the recovery window and reset each keep the pins undriven or the capture stage empty. Only the bench's scenarios can show the rest, because it depends on array contents and burst history: the interleaved address order, lane-masked writes and aborts, the data returned two edges later, read-after-write without a bubble, the dummy read that still advances, and that data survives a sleep period.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } pbs_op_e;
endpackage

// File: rtl/pbs_burst_seq.sv
`timescale 1ns/1ps
// Decodes load/continue into an operation and the address for this cycle.
module pbs_burst_seq
   import pbs_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int BURST_BITS = 2,
   parameter bit LINEAR     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              flush,
   input  logic              load,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] ext_addr,
   output pbs_op_e           cyc_op,
   output logic [ADDR_W-1:0] cyc_addr
);
   logic [ADDR_W-1:0]     base_q;
   logic [BURST_BITS-1:0] cnt_q;
   logic [BURST_BITS-1:0] cnt_nx;
   logic [BURST_BITS-1:0] low_bits;
   pbs_op_e               op_q;

   assign cnt_nx = cnt_q + 1'b1;

   generate
      if (LINEAR) begin : g_linear
         assign low_bits = base_q[BURST_BITS-1:0] + cnt_nx;
      end else begin : g_interleave
         assign low_bits = base_q[BURST_BITS-1:0] ^ cnt_nx;
      end
   endgenerate

   always_comb begin
      if (load) begin
         cyc_addr = ext_addr;
         if (!sel)    cyc_op = OP_IDLE;
         else if (wr) cyc_op = OP_WR;
         else         cyc_op = OP_RD;
      end else begin
         cyc_addr = {base_q[ADDR_W-1:BURST_BITS], low_bits};
         cyc_op   = op_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         op_q   <= OP_IDLE;
      end else if (flush) begin
         cnt_q  <= '0;
         op_q   <= OP_IDLE;
      end else if (step_en) begin
         if (load) begin
            base_q <= ext_addr;
            cnt_q  <= '0;
            op_q   <= cyc_op;
         end else begin
            cnt_q  <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/pbs_sleep_ctl.sv
`timescale 1ns/1ps
// Two-flop sleep synchroniser plus post-wake recovery window.
module pbs_sleep_ctl #(
   parameter int REC_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_in,
   output logic asleep,
   output logic blocked
);
   localparam int RW = (REC_CYCLES > 0) ? $clog2(REC_CYCLES + 1) : 1;

   logic sq1, sq2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sq1 <= 1'b0;
         sq2 <= 1'b0;
      end else begin
         sq1 <= sleep_in;
         sq2 <= sq1;
      end
   end

   assign asleep = sq2;

   generate
      if (REC_CYCLES == 0) begin : g_no_rec
         assign blocked = sq2;
      end else begin : g_rec
         logic [RW-1:0] rec_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             rec_q <= '0;
            else if (sq2)           rec_q <= RW'(REC_CYCLES);
            else if (rec_q != '0)   rec_q <= rec_q - 1'b1;
         end
         assign blocked = sq2 | (rec_q != '0);
      end
   endgenerate
endmodule

// File: rtl/pbs_lane_array.sv
`timescale 1ns/1ps
// Storage split into independently written lanes, registered read.
module pbs_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [LANES-1:0]          wr_lanes,
   input  logic [LANES*LANE_W-1:0]   wr_data,
   input  logic                      rd_en,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [LANES*LANE_W-1:0]   rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];
         logic [LANE_W-1:0] rd_q;

         always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g])
               mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
         end

         always_ff @(posedge clk) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= mem[rd_addr];
         end

         assign rd_data[g*LANE_W +: LANE_W] = rd_q;
      end
   endgenerate
endmodule

// File: rtl/pbs_sram.sv
`timescale 1ns/1ps
module pbs_sram
   import pbs_pkg::*;
#(
   parameter int LANES        = 2,
   parameter int LANE_W       = 9,
   parameter int ADDR_W       = 6,
   parameter int BURST_BITS   = 2,
   parameter bit LINEAR_BURST = 1'b0,
   parameter int REC_CYCLES   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_hold,
   input  logic                    sel,
   input  logic                    load,
   input  logic                    wr,
   input  logic [LANES-1:0]        lane_we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    oe,
   input  logic                    sleep_req,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    drive_en
);
   localparam int DATA_W = LANES * LANE_W;

   generate
      if (LANES < 1 || LANE_W < 1) begin : g_bad_width
         $error("pbs_sram: LANES and LANE_W must be positive");
      end
      if (BURST_BITS < 1 || BURST_BITS >= ADDR_W) begin : g_bad_burst
         $error("pbs_sram: BURST_BITS must lie in 1..ADDR_W-1");
      end
      if (ADDR_W > 12) begin : g_bad_depth
         $error("pbs_sram: ADDR_W too large for a model array");
      end
      if (REC_CYCLES < 0) begin : g_bad_rec
         $error("pbs_sram: REC_CYCLES must be non-negative");
      end
   endgenerate

   logic              active;
   logic              asleep;
   logic              blocked;
   pbs_op_e           cyc_op;
   pbs_op_e           op_eff;
   logic [ADDR_W-1:0] cyc_addr;

   pbs_op_e           s1_op,    s2_op;
   logic [ADDR_W-1:0] s1_addr,  s2_addr;
   logic [LANES-1:0]  s1_lanes, s2_lanes;
   logic              out_rd_q;

   assign active = !clk_hold;

   pbs_sleep_ctl #(.REC_CYCLES(REC_CYCLES)) u_sleep (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep_in (sleep_req),
      .asleep   (asleep),
      .blocked  (blocked)
   );

   pbs_burst_seq #(
      .ADDR_W     (ADDR_W),
      .BURST_BITS (BURST_BITS),
      .LINEAR     (LINEAR_BURST)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (active && !blocked),
      .flush    (blocked),
      .load     (load),
      .sel      (sel),
      .wr       (wr),
      .ext_addr (addr),
      .cyc_op   (cyc_op),
      .cyc_addr (cyc_addr)
   );

   assign op_eff = blocked ? OP_IDLE : cyc_op;

   // Two-stage command pipeline: address stage, then data stage.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_op    <= OP_IDLE;
         s1_addr  <= '0;
         s1_lanes <= '0;
         s2_op    <= OP_IDLE;
         s2_addr  <= '0;
         s2_lanes <= '0;
         out_rd_q <= 1'b0;
      end else if (asleep) begin
         s1_op    <= OP_IDLE;
         s2_op    <= OP_IDLE;
         out_rd_q <= 1'b0;
      end else if (active) begin
         s1_op    <= op_eff;
         s1_addr  <= cyc_addr;
         s1_lanes <= lane_we;
         s2_op    <= s1_op;
         s2_addr  <= s1_addr;
         s2_lanes <= s1_lanes;
         out_rd_q <= (s2_op == OP_RD);
      end
   end

   pbs_lane_array #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (active && !asleep && (s2_op == OP_WR)),
      .wr_addr  (s2_addr),
      .wr_lanes (s2_lanes),
      .wr_data  (wdata),
      .rd_en    (active && !asleep && (s2_op == OP_RD)),
      .rd_addr  (s2_addr),
      .rd_data  (rdata)
   );

   assign drive_en = out_rd_q && oe && !asleep;
endmodule

// File: rtl/pbs_sram_chk.sv
`timescale 1ns/1ps
module pbs_sram_chk #(
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_hold,
   input logic              oe,
   input logic              drive_en,
   input logic [DATA_W-1:0] rdata,
   input logic              asleep,
   input logic              blocked,
   input logic              s1_live,
   input logic              s2_wr
);
   // R1: reset keeps the pad undriven into the next cycle
   p_reset_dark_r1: assert property (@(posedge clk) !rst_n |=> !drive_en);

   // R6: drive never without output enable
   p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> oe);

   // R5: a write leaving the data stage never results in a drive
   p_wr_masks_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_wr && !clk_hold) |=> !drive_en);

   // R8: an ignored edge freezes the read data
   p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_hold && !asleep) |=> $stable(rdata));

   // R10: sleep leaves the pins undriven
   p_sleep_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |=> !drive_en);

   // R11: no command enters the pipeline during sleep or recovery
   p_recovery_r11: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> !s1_live);
endmodule

bind pbs_sram pbs_sram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_hold (clk_hold),
   .oe       (oe),
   .drive_en (drive_en),
   .rdata    (rdata),
   .asleep   (asleep),
   .blocked  (blocked),
   .s1_live  (s1_op != pbs_pkg::OP_IDLE),
   .s2_wr    (s2_op == pbs_pkg::OP_WR)
);

// File: tb/pbs_sram_tb_top.sv
`timescale 1ns/1ps
module pbs_sram_tb_top;
   localparam int REC = 4;
   localparam logic [17:0] A0 = 18'h12345, A1 = 18'h2AAAA, A2 = 18'h3C0F0,
                           A3 = 18'h0F00F, B0 = 18'h15555, B1 = 18'h3FFFF,
                           C0 = 18'h21111, M6 = 18'h3C155;

   logic        clk = 1'b0;
   logic        rst_n, clk_hold, sel, load, wr, oe, sleep_req;
   logic [1:0]  lane_we;
   logic [5:0]  addr;
   logic [17:0] wdata, rdata;
   logic        drive_en;
   int          n_chk = 0, n_err = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   pbs_sram #(.REC_CYCLES(REC)) dut_i (
      .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold), .sel(sel), .load(load),
      .wr(wr), .lane_we(lane_we), .addr(addr), .wdata(wdata), .oe(oe),
      .sleep_req(sleep_req), .rdata(rdata), .drive_en(drive_en)
   );

   typedef struct packed {
      logic        hold, s, l, w;
      logic [1:0]  ln;
      logic [5:0]  a;
      logic [17:0] wd;
      logic        o;
      logic        ede;
      logic [17:0] ed;
      logic [3:0]  req;
   } vec_t;

   // Outputs checked 1 ns after the edge of each step.
   localparam vec_t VECS [26] = '{
      '{1'b0,1'b1,1'b1,1'b1,2'b11,6'd4,18'h0,1'b0,1'b0,18'h0,4'd2}, // R2 write burst at 4
      '{1'b0,1'b0,1'b0,1'b0,2'b11,6'd0,18'h0,1'b0,1'b0,18'h0,4'd3}, // R3 addr 5, sel low
      '{1'b0,1'b0,1'b0,1'b0,2'b11,6'd0,A0,   1'b0,1'b0,18'h0,4'd4}, // R4 data for 4
      '{1'b0,1'b0,1'b0,1'b0,2'b11,6'd0,A1,   1'b0,1'b0,18'h0,4'd4}, // R4 data for 5
      '{1'b0,1'b1,1'b1,1'b1,2'b01,6'd6,A2,   1'b0,1'b0,18'h0,4'd4}, // R4 lane0 write at 6
      '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd0,A3,   1'b0,1'b0,18'h0,4'd4}, // R4 abort at 7
      '{1'b0,1'b1,1'b1,1'b0,2'b00,6'd4,B0,   1'b1,1'b0,18'h0,4'd5}, // R5 write stage, oe high
      '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd0,B1,   1'b1,1'b0,18'h0,4'd4}, // R4 abort data ignored
      '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd0,18'h0,1'b1,1'b1,A0,  4'd2}, // R2 read of 4
      '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd0,18'h0,1'b1,1'b1,A1,  4'd3}, // R3 read of 5
      '{1'b1,1'b1,1'b1,1'b1,2'b11,6'd3,18'h0,1'b1,1'b1,A1,  4'd8}, // R8 stalled edge
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'd0,18'h0,1'b1,1'b1,M6,  4'd4}, // R4 merged lanes at 6
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'd0,18'h0,1'b1,1'b1,A3,  4'd4}, // R4 abort kept 7
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'd0,18'h0,1'b1,1'b0,18'h0,4'd5}, // R5 deselect
      '{1'b0,1'b1,1'b1,1'b1,2'b11,6'd2,18'h0,1'b1,1'b0,18'h0,4'd5}, // R5 write at 2
      '{1'b0,1'b1,1'b1,1'b0,2'b00,6'd2,18'h0,1'b1,1'b0,18'h0,4'd5}, // R5 read at 2
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'd0,C0,   1'b1,1'b0,18'h0,4'd5}, // R5 write stage
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'd0,18'h0,1'b1,1'b1,C0,  4'd12}, // R12 no bubble
      '{1'b0,1'b1,1'b1,1'b0,2'b00,6'd5,18'h0,1'b1,1'b0,18'h0,4'd5}, // R5 read at 5
      '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd0,18'h0,1'b1,1'b0,18'h0,4'd5}, // R5 continue -> 4
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'd0,18'h0,1'b1,1'b1,A1,  4'd3}, // R3 first of burst
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'd0,18'h0,1'b1,1'b1,A0,  4'd3}, // R3 5 xor 1 = 4
      '{1'b0,1'b1,1'b1,1'b0,2'b00,6'd4,18'h0,1'b0,1'b0,18'h0,4'd5}, // R5 dummy read at 4
      '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd0,18'h0,1'b1,1'b0,18'h0,4'd5}, // R5 continue -> 5
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'd0,18'h0,1'b0,1'b0,18'h0,4'd7}, // R7 dummy not driven
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'd0,18'h0,1'b1,1'b1,A1,  4'd7}  // R7 advanced to 5
   };

   task automatic check(input bit ok, input int req, input logic [17:0] act,
                        input logic [17:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic h, s, l, w, input logic [1:0] ln,
                        input logic [5:0] a, input logic [17:0] d, input logic o);
      @(negedge clk);
      clk_hold = h; sel = s; load = l; wr = w; lane_we = ln;
      addr = a; wdata = d; oe = o;
      @(posedge clk);
      #1;
   endtask

   task automatic desel();
      drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 6'd0, 18'h0, 1'b1);
   endtask

   initial begin
      rst_n = 1'b0; clk_hold = 1'b0; sel = 1'b0; load = 1'b1; wr = 1'b0;
      lane_we = '0; addr = '0; wdata = '0; oe = 1'b1; sleep_req = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check(drive_en == 1'b0, 1, {17'b0, drive_en}, 18'h0); // R1 in reset, oe high
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check(drive_en == 1'b0, 1, {17'b0, drive_en}, 18'h0); // R1 after release

      for (int i = 0; i < 26; i++) begin
         drive(VECS[i].hold, VECS[i].s, VECS[i].l, VECS[i].w, VECS[i].ln,
               VECS[i].a, VECS[i].wd, VECS[i].o);
         check(drive_en == VECS[i].ede, int'(VECS[i].req),
               {17'b0, drive_en}, {17'b0, VECS[i].ede});
         if (VECS[i].ede)
            check(rdata == VECS[i].ed, int'(VECS[i].req), rdata, VECS[i].ed);
      end

      // R6: oe acts without a clock edge
      drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 6'd4, 18'h0, 1'b1);
      desel();
      desel();
      check(drive_en && rdata == A0, 6, rdata, A0);
      oe = 1'b0; #1;
      check(drive_en == 1'b0, 6, {17'b0, drive_en}, 18'h0);
      oe = 1'b1; #1;
      check(drive_en == 1'b1, 6, {17'b0, drive_en}, 18'h1);

      // R9: continuation after a deselect is itself a deselect
      drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 6'd4, 18'h0, 1'b1);
      desel();
      desel();
      check(drive_en == 1'b0, 9, {17'b0, drive_en}, 18'h0);

      // R10: sleep entry drops the pending read and ignores new ones
      sleep_req = 1'b1;
      drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 6'd4, 18'h0, 1'b1);
      desel();
      desel();
      check(drive_en == 1'b0, 10, {17'b0, drive_en}, 18'h0);
      drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 6'd4, 18'h0, 1'b1);
      desel();
      desel();
      check(drive_en == 1'b0, 10, {17'b0, drive_en}, 18'h0);

      // R11: commands during the recovery window are dropped
      sleep_req = 1'b0;
      desel();
      desel();
      drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 6'd4, 18'h0, 1'b1);
      desel();
      desel();
      check(drive_en == 1'b0, 11, {17'b0, drive_en}, 18'h0);
      desel();
      drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 6'd4, 18'h0, 1'b1);
      desel();
      desel();
      check(drive_en == 1'b1, 11, {17'b0, drive_en}, 18'h1);
      check(rdata == A0, 10, rdata, A0); // R10 contents kept through sleep

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R2: watchdog expired, actual hung expected done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule